// File: doc/BRIEF.md
# Memory attribute region lookup

This block assigns memory attributes to physical addresses. It holds a small table of region entries. Each entry has a configuration byte and a 32-bit address word, and software programs them through an indexed register port. Each configuration byte gives a match mode, a 4-bit memory type and an atomic-disable bit. Each address word describes a naturally aligned power-of-two region. The smallest region is 4 KiB.

For every address presented on the lookup port, the block compares the address against all enabled entries at the same time. The lowest-numbered entry that matches supplies the memory type and the atomic-disable flag. The result is registered, so it appears one cycle after the request. A fault flag is raised in two cases:
- the access touches an empty hole (type 15);
- an atomic access touches a region where atomic operations are disabled.

Cache and bus logic downstream consume the type code. That logic is outside this block.

Top module: `mattr_lookup`

## Requirements
- R1: After reset every entry is disabled (configuration 0, address 0). All result outputs and the read data output are 0.
- R2: Writes use `cfg_sel` = 0 for an entry's configuration byte and 1 for its address word, at index `cfg_idx`, and take effect at the clock edge. `cfg_rdata` shows, one cycle later, the value the selected register held before any write in that same cycle. For configuration reads, bits 31:7 are 0: write bit 7 is reserved and is dropped.
- R3: Configuration bits 1:0 are the match mode, bits 5:2 the memory type and bit 6 the atomic-disable flag. Only mode 3 enables an entry. Modes 0, 1 and 2 never match.
- R4: Address word bits 29:0 are compared with request address bits 31:2, and address word bits 31:30 are ignored. The word is encoded as (base >> 2) | ((size - 1) >> 3). If the word has t trailing one bits, the region covers 2^(t+3) bytes.
- R5: Address word bits 8:0 are always treated as ones. As a result, the smallest region is 4 KiB, whatever is written in those bits.
- R6: When several enabled entries match, the entry with the lowest index supplies the type and the atomic-disable flag, and `res_hit` is 1.
- R7: An address that matches no enabled entry returns type 2, atomic-disable 0 and `res_hit` 0.
- R8: A matched entry with a reserved type code (6, 7, 12, 13 or 14) reports type 2.
- R9: A result with type 15 (empty hole) always has `res_fault` = 1.
- R10: An atomic request to a region whose atomic-disable flag is 1 raises `res_fault`. Without that combination, or type 15, `res_fault` is 0.
- R11: `res_valid` follows `req_valid` one cycle later. A lookup uses the register contents from before a write in the same cycle. If `req_valid` is 0, then in the next cycle every result output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | 0 selects configuration byte, 1 selects address word |
| cfg_idx | input | 4 | Entry index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data of the selected register |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | Physical byte address |
| req_atomic | input | 1 | Request is an atomic operation |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | An enabled entry matched |
| res_type | output | 4 | Memory type |
| res_amo_dis | output | 1 | Atomic operations disabled in the region |
| res_fault | output | 1 | Access fault |

## Verification
The hardest situation to reach is overlap. An address must fall inside several enabled regions of different sizes at once, while one of those entries is being rewritten in the same cycle as the lookup.

The stimulus builds a small entry nested inside a larger one, plus regions whose address words carry junk in the low bits and the top two bits. It then issues lookups in the same cycle as writes. After that, a long random phase rewrites the upper entries with random sizes and bases drawn from a few shared windows. This keeps overlaps and boundary addresses frequent, and every cycle is compared against a behavioural model.

// File: rtl/mattr_pkg.sv
package mattr_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_RSV1  = 2'd1,
        MODE_RSV2  = 2'd2,
        MODE_NAPOT = 2'd3
    } match_mode_e;

    // Configuration byte, bits 6:0 (bit 7 is reserved and not stored).
    typedef struct packed {
        logic        amo_dis;   // bit 6
        logic [3:0]  mtype;     // bits 5:2
        match_mode_e mode;      // bits 1:0
    } entry_cfg_t;

    localparam int CFG_W = $bits(entry_cfg_t);

    localparam logic [3:0] MT_DEFAULT = 4'd2;
    localparam logic [3:0] MT_HOLE    = 4'd15;

    typedef struct packed {
        logic       valid;
        logic       hit;
        logic [3:0] mtype;
        logic       amo_dis;
        logic       fault;
    } lookup_res_t;

    // Map reserved encodings onto the non-cacheable, non-bufferable type.
    function automatic logic [3:0] fold_type(input logic [3:0] t);
        logic [3:0] r;
        case (t)
            4'd6, 4'd7, 4'd12, 4'd13, 4'd14: r = MT_DEFAULT;
            default:                         r = t;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mattr_regfile.sv
module mattr_regfile
    import mattr_pkg::*;
#(
    parameter int N_ENTRY = 16,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(N_ENTRY)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic                            sel,
    input  logic [IDX_W-1:0]                idx,
    input  logic [ADDR_W-1:0]               wdata,
    output entry_cfg_t [N_ENTRY-1:0]        cfg_o,
    output logic [N_ENTRY-1:0][ADDR_W-1:0]  addr_o,
    output logic [ADDR_W-1:0]               rdata
);

    typedef struct packed {
        entry_cfg_t [N_ENTRY-1:0]       cfg;
        logic [N_ENTRY-1:0][ADDR_W-1:0] addr;
        logic [ADDR_W-1:0]              rdata;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // read path sees the pre-write value
        if (sel) begin
            st_d.rdata = st_q.addr[idx];
        end else begin
            st_d.rdata = {{(ADDR_W-CFG_W){1'b0}}, st_q.cfg[idx]};
        end
        if (we) begin
            if (sel) begin
                st_d.addr[idx] = wdata;
            end else begin
                st_d.cfg[idx] = entry_cfg_t'(wdata[CFG_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o  = st_q.cfg;
    assign addr_o = st_q.addr;
    assign rdata  = st_q.rdata;

endmodule

// File: rtl/mattr_napot_match.sv
module mattr_napot_match #(
    parameter int WADDR_W = 30,
    parameter int FORCE_W = 9
) (
    input  logic               en,
    input  logic [WADDR_W-1:0] areg,
    input  logic [WADDR_W-1:0] waddr,
    output logic               hit
);

    logic [WADDR_W-1:0] r_eff;
    logic [WADDR_W-1:0] span;
    logic [WADDR_W-1:0] diff;

    always_comb begin
        // low bits below the granule always act as size bits
        r_eff = areg | {{(WADDR_W-FORCE_W){1'b0}}, {FORCE_W{1'b1}}};
        // ones from bit 0 up to and including the first zero
        span  = r_eff ^ (r_eff + 1'b1);
        diff  = (waddr ^ r_eff) & ~span;
        hit   = en && (diff == '0);
    end

endmodule

// File: rtl/mattr_prio_sel.sv
module mattr_prio_sel
    import mattr_pkg::*;
#(
    parameter int N_ENTRY = 16
) (
    input  logic                     valid,
    input  logic                     atomic,
    input  logic [N_ENTRY-1:0]       hits,
    input  entry_cfg_t [N_ENTRY-1:0] cfg,
    output lookup_res_t              res
);

    logic       found;
    entry_cfg_t pick;

    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N_ENTRY; i++) begin
            if (hits[i] && !found) begin
                found = 1'b1;
                pick  = cfg[i];
            end
        end

        res = '0;
        if (valid) begin
            res.valid = 1'b1;
            res.hit   = found;
            if (found) begin
                res.mtype   = fold_type(pick.mtype);
                res.amo_dis = pick.amo_dis;
            end else begin
                res.mtype   = MT_DEFAULT;
                res.amo_dis = 1'b0;
            end
            res.fault = (res.mtype == MT_HOLE) || (atomic && res.amo_dis);
        end
    end

endmodule

// File: rtl/mattr_lookup.sv
module mattr_lookup
    import mattr_pkg::*;
#(
    parameter int N_ENTRY   = 16,
    parameter int ADDR_W    = 32,
    parameter int GRAN_LOG2 = 12,
    localparam int IDX_W    = $clog2(N_ENTRY),
    localparam int WADDR_W  = ADDR_W - 2,
    localparam int FORCE_W  = GRAN_LOG2 - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_atomic,
    output logic              res_valid,
    output logic              res_hit,
    output logic [3:0]        res_type,
    output logic              res_amo_dis,
    output logic              res_fault
);

    entry_cfg_t [N_ENTRY-1:0]       ent_cfg;
    logic [N_ENTRY-1:0][ADDR_W-1:0] ent_addr;
    logic [N_ENTRY-1:0]             hits;
    lookup_res_t                    res_d, res_q;

    mattr_regfile #(
        .N_ENTRY (N_ENTRY),
        .ADDR_W  (ADDR_W)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .sel    (cfg_sel),
        .idx    (cfg_idx),
        .wdata  (cfg_wdata),
        .cfg_o  (ent_cfg),
        .addr_o (ent_addr),
        .rdata  (cfg_rdata)
    );

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_match
        mattr_napot_match #(
            .WADDR_W (WADDR_W),
            .FORCE_W (FORCE_W)
        ) u_match (
            .en    (ent_cfg[g].mode == MODE_NAPOT),
            .areg  (ent_addr[g][WADDR_W-1:0]),
            .waddr (req_addr[ADDR_W-1:2]),
            .hit   (hits[g])
        );
    end

    mattr_prio_sel #(
        .N_ENTRY (N_ENTRY)
    ) u_sel (
        .valid  (req_valid),
        .atomic (req_atomic),
        .hits   (hits),
        .cfg    (ent_cfg),
        .res    (res_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid   = res_q.valid;
    assign res_hit     = res_q.hit;
    assign res_type    = res_q.mtype;
    assign res_amo_dis = res_q.amo_dis;
    assign res_fault   = res_q.fault;

endmodule

// File: rtl/mattr_lookup_chk.sv
module mattr_lookup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_sel,
    input logic [31:0] cfg_rdata,
    input logic        req_valid,
    input logic        req_atomic,
    input logic        res_valid,
    input logic        res_hit,
    input logic [3:0]  res_type,
    input logic        res_amo_dis,
    input logic        res_fault
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);                                            // R11
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !res_hit && res_type == 4'd0 && !res_amo_dis && !res_fault)); // R11
    AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_type == 4'd2 && !res_amo_dis));     // R7
    AST_NO_RSVD_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(res_type inside {4'd6, 4'd7, 4'd12, 4'd13, 4'd14})); // R8
    AST_HOLE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_type == 4'd15) |-> res_fault);                     // R9
    AST_AMO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_amo_dis && $past(req_atomic)) |-> res_fault);      // R10
    AST_CFG_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel |=> (cfg_rdata[31:7] == 25'd0));                             // R2

endmodule

bind mattr_lookup mattr_lookup_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_sel     (cfg_sel),
    .cfg_rdata   (cfg_rdata),
    .req_valid   (req_valid),
    .req_atomic  (req_atomic),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_type    (res_type),
    .res_amo_dis (res_amo_dis),
    .res_fault   (res_fault)
);

// File: tb/tb_mattr_lookup.sv
`timescale 1ns/1ps
module tb_mattr_lookup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_atomic = 1'b0;
    logic        res_valid, res_hit, res_amo_dis, res_fault;
    logic [3:0]  res_type;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit [7:0]  m_cfg  [16];
    bit [31:0] m_addr [16];

    always #2.5 clk = ~clk;

    mattr_lookup dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .req_atomic(req_atomic),
        .res_valid(res_valid), .res_hit(res_hit), .res_type(res_type),
        .res_amo_dis(res_amo_dis), .res_fault(res_fault)
    );

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Behavioural model of one region test: count trailing ones, compare above them.
    function automatic bit in_region(input bit [31:0] areg, input bit [31:0] addr);
        longint unsigned r, a;
        int t;
        r = longint'(areg[29:0]) | 64'h1FF;
        a = longint'(addr[31:2]);
        t = 0;
        while (t < 30 && r[t]) t++;
        return (a >> (t + 1)) == (r >> (t + 1));
    endfunction

    task automatic step(input bit v, input bit [31:0] a, input bit at,
                        input bit we, input bit sel, input int idx,
                        input bit [31:0] wd, input string tag);
        bit e_hit, e_amo, e_fault;
        int e_type;
        bit [31:0] e_rd;
        @(negedge clk);
        req_valid = v; req_addr = a; req_atomic = at;
        cfg_we = we; cfg_sel = sel; cfg_idx = 4'(idx); cfg_wdata = wd;
        e_hit = 0; e_type = 2; e_amo = 0;
        for (int i = 15; i >= 0; i--) begin
            if (m_cfg[i][1:0] == 2'd3 && in_region(m_addr[i], a)) begin
                e_hit = 1;
                e_type = int'(m_cfg[i][5:2]);
                e_amo = m_cfg[i][6];
            end
        end
        if (e_type inside {6, 7, 12, 13, 14}) e_type = 2;
        e_fault = (e_type == 15) || (at && e_amo);
        if (!v) begin
            e_hit = 0; e_type = 0; e_amo = 0; e_fault = 0;
        end
        e_rd = sel ? m_addr[idx] : {25'd0, m_cfg[idx][6:0]};
        if (we) begin
            if (sel) m_addr[idx] = wd;
            else     m_cfg[idx] = {1'b0, wd[6:0]};
        end
        @(posedge clk);
        #1;
        check({tag, "/R11"}, "res_valid", res_valid, v);
        check({tag, "/R4"}, "res_hit", res_hit, e_hit);
        check({tag, "/R6"}, "res_type", res_type, e_type);
        check({tag, "/R3"}, "res_amo_dis", res_amo_dis, e_amo);
        check({tag, "/R10"}, "res_fault", res_fault, e_fault);
        check({tag, "/R2"}, "cfg_rdata", cfg_rdata, e_rd);
    endtask

    task automatic wr(input int idx, input bit sel, input bit [31:0] wd, input string tag);
        step(0, 0, 0, 1, sel, idx, wd, tag);
    endtask

    task automatic rd(input int idx, input bit sel, input string tag);
        step(0, 0, 0, 0, sel, idx, 0, tag);
    endtask

    task automatic look(input bit [31:0] a, input bit at, input string tag);
        step(1, a, at, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "res_valid", res_valid, 0);
        check("R1", "res_type", res_type, 0);
        check("R1", "res_fault", res_fault, 0);
        check("R1", "cfg_rdata", cfg_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(3, 1, "R1");
        rd(3, 0, "R1");
        look(32'h8000_0000, 1, "R1_R7");

        // R2: reserved bit 7 dropped, read-before-write
        wr(5, 0, 32'hFFFF_FFFF, "R2");
        rd(5, 0, "R2");
        step(0, 0, 0, 1, 0, 5, 32'h0, "R2");
        rd(5, 0, "R2");

        // R6: 4K entry 0 nested in 64K entry 1
        wr(0, 1, 32'h2000_01FF, "R4");
        wr(0, 0, 32'h13, "R4");
        wr(1, 1, 32'h2000_1FFF, "R6");
        wr(1, 0, 32'h27, "R6");
        rd(1, 1, "R2");
        look(32'h8000_0000, 0, "R6");
        look(32'h8000_0FFF, 0, "R6");
        look(32'h8000_1000, 0, "R6");
        look(32'h8000_FFFC, 0, "R4");
        look(32'h8001_0000, 0, "R7");
        look(32'h7FFF_FFFC, 0, "R7");

        // R5: size bits below the granule forced
        wr(2, 1, 32'h2400_0000, "R5");
        wr(2, 0, 32'h3F, "R5_R9");
        look(32'h9000_0FF0, 0, "R5_R9");
        look(32'h9000_1000, 0, "R5");

        // R3: modes 1 and 2 never match, mode 3 with atomic disable
        wr(3, 1, 32'h2800_01FF, "R3");
        wr(3, 0, 32'h21, "R3");
        look(32'hA000_0040, 0, "R3");
        wr(3, 0, 32'h22, "R3");
        look(32'hA000_0040, 1, "R3");
        wr(3, 0, 32'h63, "R10");
        look(32'hA000_0040, 1, "R10");
        look(32'hA000_0040, 0, "R10");
        wr(3, 0, 32'h23, "R10");
        look(32'hA000_0040, 1, "R10");

        // R8: reserved type folded
        wr(4, 1, 32'h2C00_01FF, "R8");
        wr(4, 0, 32'h37, "R8");
        look(32'hB000_0800, 0, "R8");

        // R4: upper two bits of the address word ignored
        wr(6, 1, 32'hF400_01FF, "R4");
        wr(6, 0, 32'h07, "R4");
        look(32'hD000_0100, 0, "R4");

        // R11: lookup uses pre-write contents, then sees the write
        step(1, 32'hD000_0100, 0, 1, 0, 6, 32'h0, "R11");
        look(32'hD000_0100, 0, "R11");

        // Random phase over shared windows
        for (int n = 0; n < 3000; n++) begin
            bit [31:0] base, a, areg;
            int sz;
            base = {2'b10, 2'($urandom_range(0, 3)), 28'h0};
            if ($urandom_range(0, 3) == 0) begin
                int idx;
                idx = $urandom_range(7, 15);
                if ($urandom_range(0, 1) == 0) begin
                    wr(idx, 0, $urandom, "R6");
                end else begin
                    sz = $urandom_range(3, 27);
                    areg = ((base + ($urandom & ~((32'd1 << sz) - 1))) >> 2) | (((32'd1 << sz) - 1) >> 3);
                    if ($urandom_range(0, 1) == 0) areg = areg | ($urandom & 32'hC000_0000);
                    wr(idx, 1, areg, "R4");
                end
            end else begin
                a = base | ($urandom & 32'h0FFF_FFFC);
                if ($urandom_range(0, 2) == 0) a = {a[31:12], 12'hFFC};
                step($urandom_range(0, 5) != 0, a, 1'($urandom), 0,
                     1'($urandom), $urandom_range(0, 15), 0, "R6");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule